// File: doc/BRIEF.md
# VLIW Packet Issue Sequencer

The sequencer pulls 32-bit instruction words one at a time from a fetch port and groups them into a very-long-instruction-word packet. A packet closes on the word whose top bit is set, or when the configured maximum number of words has been issued, whichever comes first. Each word goes to an execution port through a valid/done handshake. The sequencer marks the first and the last word of the packet on that port.

Before each word is issued, the sequencer sends a one-cycle strobe that forces general register 0 to zero. When a packet opens, it clears the pending write-back queue and sets the floating-media slot tracker to "none". After each instruction it moves the program counter to the next address reported by the execution side. When the packet closes, one commit strobe triggers exception handling and write-back, and the retired-instruction counter grows by the packet's length.

Slot assignment sits outside the block. A unit code and an error bit arrive with each word. If the error bit is set, the word still executes, but its slot is not set up and a sticky error flag is raised.

Top module: `vliw_issue_seq`

## Requirements
- R1: A word with bit 31 equal to 1 is issued with `issueLast` high, and no further word belongs to that packet.
- R2: A packet never holds more than `MAX_PKT` words (default 4). The word in position `MAX_PKT-1` is issued as last even when its bit 31 is 0.
- R3: `gr0Zero` is high for exactly the one cycle just before each word's first `issueValid` cycle.
- R4: `issueFirst` is high only for the first word of a packet. `issueLast` is high only for the word that closes it.
- R5: Each packet opens with a one-cycle `wbClear` pulse, and in the cycle after that pulse `fmSlot` reads 0 (none).
- R6: Unit codes 4, 5, 6 and 7 are floating-media units 0 to 3. An accepted, error-free word with such a code sets `fmSlot` to that code. At commit, `fmSlot` shows the last such code in the packet, or 0.
- R7: `fetchPc` shows the current program counter. On each `execDone` the counter takes `execNextPc`.
- R8: `pktCommit` pulses once per packet, after the closing word's `execDone` and before the next `wbClear`.
- R9: `retiredCount` starts at 0 and grows by the packet's word count at each commit, and is otherwise unchanged.
- R10: A word with `fetchSlotErr` high is still issued, with `issueSlot` equal to 0. It does not change `fmSlot`, and it sets `slotErrSticky`, which stays high until reset.
- R11: `issueValid` stays high with a stable word until `execDone` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | output | ADDR_W | Current program counter / fetch address |
| fetchReady | output | 1 | Sequencer can accept a word |
| fetchValid | input | 1 | Fetch word is present |
| fetchWord | input | 32 | Instruction word; bit 31 ends the packet |
| fetchSlot | input | 4 | Assigned unit code (0 none, 4-7 floating-media) |
| fetchSlotErr | input | 1 | Slot assignment failed for this word |
| gr0Zero | output | 1 | Force general register 0 to zero |
| issueValid | output | 1 | Word is offered for execution |
| issueWord | output | 32 | Word being issued |
| issueSlot | output | 4 | Slot set up for the word (0 on error) |
| issueFirst | output | 1 | Word opens the packet |
| issueLast | output | 1 | Word closes the packet |
| execDone | input | 1 | Execution of the offered word finished |
| execNextPc | input | ADDR_W | Address of the next instruction |
| wbClear | output | 1 | Clear write-back queue at packet start |
| pktCommit | output | 1 | Packet end: run exceptions and write-back |
| fmSlot | output | 4 | Last floating-media unit used in the packet |
| retiredCount | output | CNT_W | Retired-instruction count |
| slotErrSticky | output | 1 | A slot error has occurred since reset |

## Verification
The assertions assume a well-behaved environment in four respects:
- `execDone` arrives only while `issueValid` is high.
- `fetchValid` is offered only while `fetchReady` is high.
- `fetchValid` is dropped once the word has been taken.
- `execNextPc` is valid together with `execDone`.

The bench keeps to these rules by reacting at the falling edge to the outputs it sees. It raises each handshake only while the matching ready or valid is shown, and lowers it in the cycle after. It runs all sixteen end-bit patterns over four-word groups, with varied fetch and execution delays, slot codes that cover every floating-media unit, and scattered slot errors.

// File: rtl/vliw_seq_pkg.sv
package vliw_seq_pkg;
  localparam int UNIT_W = 4;
  localparam logic [UNIT_W-1:0] UNIT_NONE = '0;
  localparam int FM_FIRST = 4;
  localparam int FM_UNITS = 4;

  typedef enum logic [2:0] {
    ST_START, ST_FETCH, ST_ZERO, ST_ISSUE, ST_END
  } seqState_t;

  typedef struct packed {
    logic initPkt;
    logic capture;
    logic issueDone;
    logic commit;
  } seqStrobe_t;
endpackage

// File: rtl/vliw_seq_ctrl.sv
module vliw_seq_ctrl
  import vliw_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic       execDone,
  input  logic       endOfPacket,
  output seqStrobe_t strobe,
  output logic       fetchReady,
  output logic       gr0Zero,
  output logic       issueValid,
  output logic       wbClear,
  output logic       pktCommit
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_START;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_START: stateNext = ST_FETCH;
      ST_FETCH: if (fetchValid) stateNext = ST_ZERO;
      ST_ZERO:  stateNext = ST_ISSUE;
      ST_ISSUE: if (execDone) stateNext = endOfPacket ? ST_END : ST_FETCH;
      ST_END:   stateNext = ST_START;
      default:  stateNext = ST_START;
    endcase
  end

  assign fetchReady = (state == ST_FETCH);
  assign gr0Zero    = (state == ST_ZERO);
  assign issueValid = (state == ST_ISSUE);
  assign wbClear    = (state == ST_START);
  assign pktCommit  = (state == ST_END);

  always_comb begin
    strobe           = '0;
    strobe.initPkt   = wbClear;
    strobe.capture   = fetchReady && fetchValid;
    strobe.issueDone = issueValid && execDone;
    strobe.commit    = pktCommit;
  end

  // R3: a zero strobe is always followed by an issue
  p_zero_then_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    gr0Zero |=> issueValid);
  // R3: an accepted word leads straight to the zero strobe
  p_accept_then_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReady && fetchValid) |=> gr0Zero);
  // R11: offer held until done
  p_issue_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !execDone) |=> issueValid);
  // R8: commit is followed by the next packet start
  p_commit_then_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktCommit |=> wbClear);
endmodule

// File: rtl/vliw_seq_dp.sv
module vliw_seq_dp
  import vliw_seq_pkg::*;
#(
  parameter int MAX_PKT = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [31:0]       fetchWord,
  input  logic [UNIT_W-1:0] fetchSlot,
  input  logic              fetchSlotErr,
  input  logic [ADDR_W-1:0] execNextPc,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [31:0]       issueWord,
  output logic [UNIT_W-1:0] issueSlot,
  output logic              issueFirst,
  output logic              issueLast,
  output logic              endOfPacket,
  output logic [UNIT_W-1:0] fmSlot,
  output logic [CNT_W-1:0]  retiredCount,
  output logic              slotErrSticky
);
  localparam int IDX_W = $clog2(MAX_PKT + 1);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(MAX_PKT - 1);

  logic [ADDR_W-1:0] pcReg;
  logic [31:0]       wordReg;
  logic [UNIT_W-1:0] slotReg, fmReg;
  logic [IDX_W-1:0]  pktCount;
  logic [CNT_W-1:0]  retReg;
  logic              stickyReg;
  logic [FM_UNITS-1:0] fmHit;
  logic              isFm;

  for (genvar g = 0; g < FM_UNITS; g++) begin : g_fm
    assign fmHit[g] = (fetchSlot == UNIT_W'(FM_FIRST + g));
  end
  assign isFm = (|fmHit) && !fetchSlotErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg     <= RESET_PC;
      wordReg   <= '0;
      slotReg   <= UNIT_NONE;
      fmReg     <= UNIT_NONE;
      pktCount  <= '0;
      retReg    <= '0;
      stickyReg <= 1'b0;
    end else begin
      if (strobe.initPkt) begin
        pktCount <= '0;
        fmReg    <= UNIT_NONE;
      end
      if (strobe.capture) begin
        wordReg <= fetchWord;
        slotReg <= fetchSlotErr ? UNIT_NONE : fetchSlot;
        if (isFm) fmReg <= fetchSlot;
        if (fetchSlotErr) stickyReg <= 1'b1;
      end
      if (strobe.issueDone) begin
        pcReg    <= execNextPc;
        pktCount <= pktCount + 1'b1;
      end
      if (strobe.commit) retReg <= retReg + CNT_W'(pktCount);
    end
  end

  assign fetchPc       = pcReg;
  assign issueWord     = wordReg;
  assign issueSlot     = slotReg;
  assign issueFirst    = (pktCount == '0);
  assign issueLast     = wordReg[31] || (pktCount == LAST_POS);
  assign endOfPacket   = issueLast;
  assign fmSlot        = fmReg;
  assign retiredCount  = retReg;
  assign slotErrSticky = stickyReg;

  // R2: packet length bounded
  p_pkt_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    pktCount <= IDX_W'(MAX_PKT));
  // R9: counter moves only on commit
  p_retired_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(retiredCount));
  // R10: error flag is sticky
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotErrSticky |=> slotErrSticky);
  // R5: tracker reads none after packet start
  p_fm_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initPkt |=> (fmSlot == UNIT_NONE));
  // R7: pc steady between completions
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issueDone |=> $stable(fetchPc));
endmodule

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq
  import vliw_seq_pkg::*;
#(
  parameter int MAX_PKT = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              fetchReady,
  input  logic              fetchValid,
  input  logic [31:0]       fetchWord,
  input  logic [3:0]        fetchSlot,
  input  logic              fetchSlotErr,
  output logic              gr0Zero,
  output logic              issueValid,
  output logic [31:0]       issueWord,
  output logic [3:0]        issueSlot,
  output logic              issueFirst,
  output logic              issueLast,
  input  logic              execDone,
  input  logic [ADDR_W-1:0] execNextPc,
  output logic              wbClear,
  output logic              pktCommit,
  output logic [3:0]        fmSlot,
  output logic [CNT_W-1:0]  retiredCount,
  output logic              slotErrSticky
);
  seqStrobe_t strobe;
  logic       endOfPacket;

  vliw_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .execDone(execDone),
    .endOfPacket(endOfPacket), .strobe(strobe), .fetchReady(fetchReady),
    .gr0Zero(gr0Zero), .issueValid(issueValid), .wbClear(wbClear),
    .pktCommit(pktCommit)
  );

  vliw_seq_dp #(
    .MAX_PKT(MAX_PKT), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchWord(fetchWord),
    .fetchSlot(fetchSlot), .fetchSlotErr(fetchSlotErr), .execNextPc(execNextPc),
    .fetchPc(fetchPc), .issueWord(issueWord), .issueSlot(issueSlot),
    .issueFirst(issueFirst), .issueLast(issueLast), .endOfPacket(endOfPacket),
    .fmSlot(fmSlot), .retiredCount(retiredCount), .slotErrSticky(slotErrSticky)
  );
endmodule

// File: tb/vliw_issue_seq_tb.sv
module vliw_issue_seq_tb_top;
  localparam int MAX_PKT = 4;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] fetchPc, execNextPc, fetchWord, issueWord;
  logic fetchReady, fetchValid, fetchSlotErr, gr0Zero, issueValid;
  logic issueFirst, issueLast, execDone, wbClear, pktCommit, slotErrSticky;
  logic [3:0] fetchSlot, issueSlot, fmSlot;
  logic [15:0] retiredCount;

  vliw_issue_seq #(.MAX_PKT(MAX_PKT)) dut_i (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchReady(fetchReady),
    .fetchValid(fetchValid), .fetchWord(fetchWord), .fetchSlot(fetchSlot),
    .fetchSlotErr(fetchSlotErr), .gr0Zero(gr0Zero), .issueValid(issueValid),
    .issueWord(issueWord), .issueSlot(issueSlot), .issueFirst(issueFirst),
    .issueLast(issueLast), .execDone(execDone), .execNextPc(execNextPc),
    .wbClear(wbClear), .pktCommit(pktCommit), .fmSlot(fmSlot),
    .retiredCount(retiredCount), .slotErrSticky(slotErrSticky)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input int i);
    int blk = i / 4;
    logic lastBit = 1'((blk >> (i % 4)) & 1);
    return {lastBit, 31'(i * 32'h1111 + 5)};
  endfunction
  function automatic logic [3:0] slotOf(input int i);
    return 4'(i % 9);
  endfunction
  function automatic logic errOf(input int i);
    return (i % 7) == 3;
  endfunction

  int k = 0, accIdx = 0, pos = 0, fdly = 0, edly = 0;
  int expRetired = 0;
  logic [31:0] expPc = '0;
  logic [3:0] expFm = '0;
  logic expSticky = 0, expLast = 0, pktDone = 0;
  logic issChecked = 0, prevZero = 0, prevWait = 0, checkFmNone = 0, done = 0;

  initial begin
    fetchValid = 0; fetchWord = '0; fetchSlot = '0; fetchSlotErr = 0;
    execDone = 0; execNextPc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    check(retiredCount == 0, "R9 reset retired", retiredCount, 0);
    check(fmSlot == 0, "R5 reset fmSlot", fmSlot, 0);
    check(slotErrSticky == 0, "R10 reset sticky", slotErrSticky, 0);
    check(fetchPc == 0, "R7 reset pc", fetchPc, 0);
    check(!issueValid && !pktCommit && !gr0Zero, "R8 reset idle", issueValid, 0);
    rstN = 1;
    checkFmNone = 1;
    for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
      @(negedge clk);
      if (checkFmNone) begin
        check(fmSlot == 0, "R5 fmSlot none at packet start", fmSlot, 0);
        checkFmNone = 0;
      end
      if (prevWait)
        check(issueValid == 1, "R11 issue held until done", issueValid, 1);
      if (wbClear) begin
        check(pos == 0, "R5 clear only at packet start", pos, 0);
        check(retiredCount == 16'(expRetired), "R9 retired count", retiredCount, expRetired);
        checkFmNone = 1;
        if (k == NW) done = 1;
      end
      if (pktCommit) begin
        check(pktDone == 1, "R8 commit after closing word", pktDone, 1);
        check(fmSlot == expFm, "R6 fm slot at commit", fmSlot, expFm);
        check(slotErrSticky == expSticky, "R10 sticky at commit", slotErrSticky, expSticky);
        expRetired += pos;
        pos = 0; pktDone = 0; expFm = '0;
      end
      if (issueValid) begin
        if (!issChecked) begin
          check(prevZero == 1, "R3 gr0 zero before issue", prevZero, 1);
          check(issueWord == wordOf(accIdx), "R11 issued word", issueWord, wordOf(accIdx));
          check(issueFirst == (pos == 0), "R4 first flag", issueFirst, pos == 0);
          if (wordOf(accIdx)[31])
            check(issueLast == 1, "R1 end bit closes packet", issueLast, 1);
          else
            check(issueLast == expLast, "R2 size cap last flag", issueLast, expLast);
          check(issueSlot == (errOf(accIdx) ? 4'd0 : slotOf(accIdx)), "R10 issued slot",
                issueSlot, errOf(accIdx) ? 4'd0 : slotOf(accIdx));
          check(fetchPc == expPc, "R7 pc during issue", fetchPc, expPc);
          issChecked = 1;
          edly = accIdx % 3;
        end
        if (edly == 0) begin
          execDone = 1;
          execNextPc = (accIdx % 5 == 2) ? expPc + 32'h40 : expPc + 32'h4;
          expPc = execNextPc;
          pos++;
          if (expLast) pktDone = 1;
          prevWait = 0;
        end else begin
          edly--;
          prevWait = 1;
        end
      end else begin
        execDone = 0;
        issChecked = 0;
        prevWait = 0;
      end
      if (fetchReady && !fetchValid && k < NW) begin
        check(fetchPc == expPc, "R7 fetch pc", fetchPc, expPc);
        if (fdly == 0) begin
          fetchValid = 1;
          fetchWord = wordOf(k);
          fetchSlot = slotOf(k);
          fetchSlotErr = errOf(k);
          accIdx = k;
          expLast = wordOf(k)[31] || (pos == MAX_PKT - 1);
          if (!errOf(k) && slotOf(k) >= 4 && slotOf(k) <= 7) expFm = slotOf(k);
          if (errOf(k)) expSticky = 1;
          k++;
          fdly = k % 2;
        end else fdly--;
      end else begin
        fetchValid = 0;
      end
      prevZero = gr0Zero;
    end
    if (!done) check(0, "watchdog expired", k, NW);
    check(retiredCount == 16'(NW), "R9 total retired", retiredCount, NW);
    check(slotErrSticky == 1, "R10 sticky final", slotErrSticky, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule